// File: doc/BRIEF.md
# Nine-bit request receiver

This block sits behind a UART whose frames carry nine data bits. The ninth bit of a received symbol says that the byte opens a new request. Incoming symbols are first kept in a circular buffer. A framer then drains that buffer one byte per clock. It assembles an eight-byte request header and, when the header asks for one, a payload. Payload bytes are streamed to the command handler as they arrive, and a one-cycle completion pulse marks the end of each request.

The block keeps a sticky error status with four causes: buffer overflow, UART overrun, framing error and assembly timeout. A status read returns the value and clears it. On the transmit side the block builds the first symbol of every reply. That symbol has its ninth bit set and carries the request identifier and a has-payload flag. When the reply has a payload, the block then sends the payload length. If no reply has started for a configurable number of cycles, it sends a keep-alive symbol on its own.

Top module: `nfr_receiver`

## Requirements
- R1: A symbol with bit 8 set starts a header. The eight header bytes arrive as type, code, value low, value high, index low, index high, length low, length high. The completed request presents value, index and length as 16-bit fields.
- R2: A request whose type has bit 7 set (device-to-host), or whose length is zero, completes on its eighth header byte. `req_done` pulses one cycle after that byte is consumed, and no payload byte follows.
- R3: Otherwise `length` payload bytes follow. Each one appears on `pl_valid`/`pl_data` one cycle after it is consumed, and `req_done` pulses together with the last of them.
- R4: A symbol without bit 8 that arrives while no request is open is discarded. It produces no `req_done`, no `pl_valid` and no `busy`.
- R5: A start symbol that arrives while a header or payload is incomplete sets error bit 3 (timeout) and restarts assembly with that symbol as the type byte.
- R6: The buffer holds 8 + MAX_PAYLOAD symbols. A symbol written while the buffer is full is dropped and sets error bit 0 (overflow). Bytes are consumed only while `cmd_stall` is low.
- R7: `rx_overrun` sets error bit 1 and `rx_frame_err` sets error bit 2, each with `rx_valid`. All error bits stay set until they are cleared.
- R8: `status_rd` clears the error status. An error event in the same cycle stays set.
- R9: A reply start sends a first symbol with bit 8 = 1, bit 7 = (rep_len != 0), bits 6..4 = 0 and bits 3..0 = bits 3..0 of the last completed request's type. When rep_len is nonzero, it then sends {0, rep_len}.
- R10: A symbol on `tx_sym` stays unchanged, with `tx_valid` high, until `tx_ready` accepts it.
- R11: When more than KA_CYCLES cycles have passed since the last reply or keep-alive start and the transmitter is idle, the symbol {1, KA_ID} is sent.
- R12: A `rep_start` in the cycle a keep-alive falls due wins. A `rep_start` while `tx_busy` is high is ignored.
- R13: `busy` is high while a header or payload is partly assembled.
- R14: After reset, no request is open, the error status is zero and nothing is transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received symbol is present |
| rx_sym | input | 9 | Received symbol, bit 8 = start marker |
| rx_overrun | input | 1 | UART lost data before this symbol |
| rx_frame_err | input | 1 | UART saw a bad stop bit |
| cmd_stall | input | 1 | Handler busy, hold consumption |
| req_done | output | 1 | Request complete pulse |
| req_type | output | 8 | Header type byte |
| req_code | output | 8 | Header code byte |
| req_value | output | 16 | Header value field |
| req_index | output | 16 | Header index field |
| req_length | output | 16 | Header length field |
| pl_valid | output | 1 | Payload byte strobe |
| pl_data | output | 8 | Payload byte |
| busy | output | 1 | Request partly assembled |
| status_rd | input | 1 | Read and clear error status |
| err_status | output | 4 | Sticky errors: 0 overflow, 1 overrun, 2 frame, 3 timeout |
| rep_start | input | 1 | Start a reply |
| rep_len | input | 8 | Reply payload length |
| tx_busy | output | 1 | Reply or keep-alive in progress |
| tx_valid | output | 1 | Transmit symbol valid |
| tx_sym | output | 9 | Transmit symbol, bit 8 = reply start |
| tx_ready | input | 1 | Transmitter accepts symbol |

## Verification
The error status can be cleared by `status_rd` in the same cycle that a new error is raised. The bench provokes this by pulsing `status_rd` together with a symbol that carries `rx_frame_err`. It expects only the frame bit to remain afterwards, so a set event must survive the clear. A reply request is also timed to land in the very cycle a keep-alive falls due, and the bench judges that the reply symbol, not the keep-alive, appears. A behavioural model in the bench compares every output on every clock.

// File: rtl/nfr_pkg.sv
// Shared constants for the nine-bit request receiver.
package nfr_pkg;
    localparam int HDR_BYTES    = 8;   // fixed header length
    localparam int ERR_W        = 4;   // error status width
    localparam int ERR_OVERFLOW = 0;
    localparam int ERR_OVERRUN  = 1;
    localparam int ERR_FRAME    = 2;
    localparam int ERR_TIMEOUT  = 3;
    localparam int D2H_BIT      = 7;   // device-to-host flag in type byte
    localparam int ID_W         = 4;   // reply identifier width
    typedef logic [8:0] sym_t;         // bit 8 = start marker
endpackage

// File: rtl/nfr_rxbuf.sv
// Circular receive buffer of nine-bit symbols.
// Assumes one write and one read request per cycle at most; a write seen
// while full (state before the edge) is dropped. One slot stays unused so
// full and empty follow from the two pointers alone.
module nfr_rxbuf
    import nfr_pkg::*;
#(
    parameter int DEPTH = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  sym_t wr_sym,
    input  logic rd_en,
    output sym_t rd_sym,
    output logic empty,
    output logic full
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0] wp, rp;
    sym_t          mem [DEPTH];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty  = (wp == rp);
    assign full   = (step(wp) == rp);
    assign rd_sym = mem[rp];

    // Store an accepted symbol.
    always_ff @(posedge clk) begin
        if (wr_en && !full) mem[wp] <= wr_sym;
    end

    // Advance the write and read pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (wr_en && !full) wp <= step(wp);
            if (rd_en && !empty) rp <= step(rp);
        end
    end

    // R6: a full buffer that is not read stays full
    a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full);
endmodule

// File: rtl/nfr_framer.sv
// Request framer: consumes one symbol per pop and builds the 8-byte header
// and the payload. Assumes the caller pops only when a symbol is present.
// A start symbol always restarts assembly; a start during an open request
// raises timeout_evt in the same cycle.
module nfr_framer
    import nfr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pop,
    input  sym_t        sym,
    output logic        timeout_evt,
    output logic        req_done,
    output logic [7:0]  req_type,
    output logic [7:0]  req_code,
    output logic [15:0] req_value,
    output logic [15:0] req_index,
    output logic [15:0] req_length,
    output logic        pl_valid,
    output logic [7:0]  pl_data,
    output logic        busy
);
    localparam int POS_W = $clog2(HDR_BYTES);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(HDR_BYTES - 1);

    logic [7:0]       hdr [HDR_BYTES];
    logic [POS_W-1:0] pos;
    logic             in_pay;
    logic [15:0]      left;
    logic             st;
    logic [7:0]       d;
    logic [15:0]      len_now;

    assign st          = sym[8];
    assign d           = sym[7:0];
    assign len_now     = {d, hdr[6]};
    assign busy        = (pos != '0) || in_pay;
    assign timeout_evt = pop && st && busy;

    assign req_type   = hdr[0];
    assign req_code   = hdr[1];
    assign req_value  = {hdr[3], hdr[2]};
    assign req_index  = {hdr[5], hdr[4]};
    assign req_length = {hdr[7], hdr[6]};

    // Header/payload assembly and completion strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos      <= '0;
            in_pay   <= 1'b0;
            left     <= '0;
            req_done <= 1'b0;
            pl_valid <= 1'b0;
            pl_data  <= '0;
            for (int i = 0; i < HDR_BYTES; i++) hdr[i] <= '0;
        end else begin
            req_done <= 1'b0;
            pl_valid <= 1'b0;
            if (pop) begin
                if (st) begin
                    hdr[0] <= d;
                    pos    <= POS_W'(1);
                    in_pay <= 1'b0;
                end else if (in_pay) begin
                    pl_valid <= 1'b1;
                    pl_data  <= d;
                    left     <= left - 1'b1;
                    if (left == 16'd1) begin
                        in_pay   <= 1'b0;
                        req_done <= 1'b1;
                    end
                end else if (pos != '0) begin
                    hdr[pos] <= d;
                    if (pos == POS_LAST) begin
                        pos <= '0;
                        if (!hdr[0][D2H_BIT] && len_now != 16'd0) begin
                            in_pay <= 1'b1;
                            left   <= len_now;
                        end else begin
                            req_done <= 1'b1;
                        end
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
            end
        end
    end

    // R1: a start symbol opens a request on the next cycle
    a_r1_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && st) |=> (busy && !req_done));
    // R4: a stray byte with no open request leaves no trace
    a_r4_garbage_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !st && !busy) |=> (!busy && !req_done && !pl_valid));
    // R3: completions are single-cycle pulses
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);
endmodule

// File: rtl/nfr_replytx.sv
// Reply-start and keep-alive transmitter. Sends a marked first symbol and,
// for replies with payload, the length symbol. Assumes the handler waits for
// tx_busy low before rep_start; a start while busy is ignored. The idle
// counter saturates one above KA_CYCLES, which is the keep-alive condition.
module nfr_replytx
    import nfr_pkg::*;
#(
    parameter int         KA_CYCLES = 750000,
    parameter logic [7:0] KA_ID     = 8'h40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_done,
    input  logic [ID_W-1:0] req_id,
    input  logic            rep_start,
    input  logic [7:0]      rep_len,
    input  logic            tx_ready,
    output logic            tx_valid,
    output sym_t            tx_sym,
    output logic            tx_busy
);
    localparam int CW = $clog2(KA_CYCLES + 2);
    localparam logic [CW-1:0] KA_TOP = CW'(KA_CYCLES + 1);

    typedef enum logic [1:0] {TX_IDLE, TX_HEAD, TX_LEN} ph_t;

    ph_t             ph;
    logic [7:0]      len_r;
    logic [CW-1:0]   idle_cnt;
    logic [ID_W-1:0] id_r, id_now;
    logic            ka_due;

    assign id_now   = req_done ? req_id : id_r;
    assign ka_due   = (idle_cnt == KA_TOP);
    assign tx_valid = (ph != TX_IDLE);
    assign tx_busy  = tx_valid;

    // Sequence reply and keep-alive symbols, track idle time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= TX_IDLE;
            tx_sym   <= '0;
            len_r    <= '0;
            idle_cnt <= '0;
            id_r     <= '0;
        end else begin
            if (req_done) id_r <= req_id;
            if (!ka_due) idle_cnt <= idle_cnt + 1'b1;
            case (ph)
                TX_IDLE: begin
                    if (rep_start) begin
                        tx_sym   <= {1'b1, rep_len != 8'd0, {(7 - ID_W){1'b0}}, id_now};
                        len_r    <= rep_len;
                        ph       <= TX_HEAD;
                        idle_cnt <= '0;
                    end else if (ka_due) begin
                        tx_sym   <= {1'b1, KA_ID};
                        len_r    <= '0;
                        ph       <= TX_HEAD;
                        idle_cnt <= '0;
                    end
                end
                TX_HEAD: begin
                    if (tx_ready) begin
                        if (len_r != 8'd0) begin
                            tx_sym <= {1'b0, len_r};
                            ph     <= TX_LEN;
                        end else begin
                            ph <= TX_IDLE;
                        end
                    end
                end
                TX_LEN:  if (tx_ready) ph <= TX_IDLE;
                default: ph <= TX_IDLE;
            endcase
        end
    end

    // R10: an unaccepted symbol is held
    a_r10_hold_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_sym)));
    // R9: every transmission opens with a marked symbol
    a_r9_marked_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_sym[8]);
endmodule

// File: rtl/nfr_receiver.sv
// Nine-bit framed request receiver top: receive buffer, framer, sticky
// error status and reply-start transmitter. Assumes rx flags are valid only
// with rx_valid, and that status_rd is a one-cycle pulse.
module nfr_receiver
    import nfr_pkg::*;
#(
    parameter int         MAX_PAYLOAD = 16,
    parameter int         KA_CYCLES   = 750000,
    parameter logic [7:0] KA_ID       = 8'h40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [8:0]  rx_sym,
    input  logic        rx_overrun,
    input  logic        rx_frame_err,
    input  logic        cmd_stall,
    output logic        req_done,
    output logic [7:0]  req_type,
    output logic [7:0]  req_code,
    output logic [15:0] req_value,
    output logic [15:0] req_index,
    output logic [15:0] req_length,
    output logic        pl_valid,
    output logic [7:0]  pl_data,
    output logic        busy,
    input  logic        status_rd,
    output logic [3:0]  err_status,
    input  logic        rep_start,
    input  logic [7:0]  rep_len,
    output logic        tx_busy,
    output logic        tx_valid,
    output logic [8:0]  tx_sym,
    input  logic        tx_ready
);
    localparam int DEPTH = HDR_BYTES + MAX_PAYLOAD + 1;

    sym_t             buf_sym;
    logic             buf_empty, buf_full, pop, tmo_evt;
    logic [ERR_W-1:0] err_r, err_evt;

    assign pop = !buf_empty && !cmd_stall;

    nfr_rxbuf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rx_valid), .wr_sym(rx_sym),
        .rd_en(pop), .rd_sym(buf_sym),
        .empty(buf_empty), .full(buf_full)
    );

    nfr_framer u_framer (
        .clk(clk), .rst_n(rst_n),
        .pop(pop), .sym(buf_sym),
        .timeout_evt(tmo_evt),
        .req_done(req_done), .req_type(req_type), .req_code(req_code),
        .req_value(req_value), .req_index(req_index), .req_length(req_length),
        .pl_valid(pl_valid), .pl_data(pl_data), .busy(busy)
    );

    nfr_replytx #(.KA_CYCLES(KA_CYCLES), .KA_ID(KA_ID)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .req_done(req_done), .req_id(req_type[ID_W-1:0]),
        .rep_start(rep_start), .rep_len(rep_len),
        .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_sym(tx_sym), .tx_busy(tx_busy)
    );

    // Collect this cycle's error events.
    always_comb begin
        err_evt               = '0;
        err_evt[ERR_OVERFLOW] = rx_valid && buf_full;
        err_evt[ERR_OVERRUN]  = rx_valid && rx_overrun;
        err_evt[ERR_FRAME]    = rx_valid && rx_frame_err;
        err_evt[ERR_TIMEOUT]  = tmo_evt;
    end

    // Sticky status: read clears, same-cycle events win.
    always_ff @(posedge clk) begin
        if (!rst_n) err_r <= '0;
        else        err_r <= (status_rd ? '0 : err_r) | err_evt;
    end

    assign err_status = err_r;

    // R8: a read with no new event leaves zero
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && err_evt == '0) |=> (err_status == '0));
    // R6: a write into a full buffer is flagged
    a_r6_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && buf_full) |=> err_status[ERR_OVERFLOW]);
    // R7: overrun stays until read
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status[ERR_OVERRUN] && !status_rd) |=> err_status[ERR_OVERRUN]);
    // R5: a start during assembly is flagged
    a_r5_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_evt |=> err_status[ERR_TIMEOUT]);
endmodule

// File: tb/nfr_receiver_bench.sv
module nfr_receiver_bench;
    localparam int         CLK_PERIOD = 10;
    localparam int         MAXP       = 8;
    localparam int         KA         = 30;
    localparam logic [7:0] KAID       = 8'h5A;
    localparam int         CAP        = 8 + MAXP;

    logic clk = 0, rst_n = 0;
    logic rx_valid = 0, rx_overrun = 0, rx_frame_err = 0, cmd_stall = 0;
    logic [8:0] rx_sym = '0;
    logic status_rd = 0, rep_start = 0, tx_ready = 1;
    logic [7:0] rep_len = '0;
    logic req_done, pl_valid, busy, tx_busy, tx_valid;
    logic [7:0] req_type, req_code, pl_data;
    logic [15:0] req_value, req_index, req_length;
    logic [3:0] err_status;
    logic [8:0] tx_sym;

    int total = 0, bad = 0, cycles = 0, dcount = 0, pcount = 0;
    logic [15:0] last_value;

    always #(CLK_PERIOD/2) clk = ~clk;

    nfr_receiver #(.MAX_PAYLOAD(MAXP), .KA_CYCLES(KA), .KA_ID(KAID)) u_nfr_receiver (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sym(rx_sym),
        .rx_overrun(rx_overrun), .rx_frame_err(rx_frame_err), .cmd_stall(cmd_stall),
        .req_done(req_done), .req_type(req_type), .req_code(req_code),
        .req_value(req_value), .req_index(req_index), .req_length(req_length),
        .pl_valid(pl_valid), .pl_data(pl_data), .busy(busy),
        .status_rd(status_rd), .err_status(err_status),
        .rep_start(rep_start), .rep_len(rep_len), .tx_busy(tx_busy),
        .tx_valid(tx_valid), .tx_sym(tx_sym), .tx_ready(tx_ready)
    );

    // ---------------- behavioural reference model ----------------
    logic [8:0] q[$];
    logic [7:0] m_hdr [8];
    int m_pos = 0, m_left = 0, m_ph = 0, m_idle = 0;
    bit m_inpay = 0, m_done = 0, m_plv = 0;
    logic [7:0] m_pld = '0, m_len = '0;
    logic [3:0] m_err = '0, m_id = '0;
    logic [8:0] m_txs = '0;

    always @(posedge clk) begin
        bit od;
        logic [3:0] idn, ev;
        logic [8:0] b;
        int sz, ln;
        if (!rst_n) begin
            q.delete();
            foreach (m_hdr[i]) m_hdr[i] = '0;
            m_pos = 0; m_left = 0; m_ph = 0; m_idle = 0; m_inpay = 0;
            m_done = 0; m_plv = 0; m_pld = '0; m_len = '0; m_err = '0;
            m_id = '0; m_txs = '0;
        end else begin
            od  = m_done;
            idn = od ? m_hdr[0][3:0] : m_id;
            if (od) m_id = m_hdr[0][3:0];
            if (m_ph == 0) begin
                if (rep_start) begin
                    m_txs = {1'b1, rep_len != 8'd0, 3'b000, idn};
                    m_len = rep_len; m_ph = 1; m_idle = 0;
                end else if (m_idle == KA + 1) begin
                    m_txs = {1'b1, KAID}; m_len = 0; m_ph = 1; m_idle = 0;
                end else m_idle++;
            end else begin
                if (m_idle < KA + 1) m_idle++;
                if (tx_ready) begin
                    if (m_ph == 1 && m_len != 0) begin m_txs = {1'b0, m_len}; m_ph = 2; end
                    else m_ph = 0;
                end
            end
            ev = '0; sz = q.size(); m_done = 0; m_plv = 0;
            if (sz > 0 && !cmd_stall) begin
                b = q.pop_front();
                if (b[8]) begin
                    if (m_pos != 0 || m_inpay) ev[3] = 1;
                    m_hdr[0] = b[7:0]; m_pos = 1; m_inpay = 0;
                end else if (m_inpay) begin
                    m_plv = 1; m_pld = b[7:0]; m_left--;
                    if (m_left == 0) begin m_inpay = 0; m_done = 1; end
                end else if (m_pos != 0) begin
                    m_hdr[m_pos] = b[7:0];
                    if (m_pos == 7) begin
                        ln = {b[7:0], m_hdr[6]};
                        m_pos = 0;
                        if (!m_hdr[0][7] && ln != 0) begin m_inpay = 1; m_left = ln; end
                        else m_done = 1;
                    end else m_pos++;
                end
            end
            if (rx_valid) begin
                if (sz == CAP) ev[0] = 1; else q.push_back(rx_sym);
                if (rx_overrun) ev[1] = 1;
                if (rx_frame_err) ev[2] = 1;
            end
            m_err = (status_rd ? 4'b0 : m_err) | ev;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", what, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        check(req_done === m_done, "R2 req_done", req_done, m_done);
        if (m_done) begin
            check(req_type === m_hdr[0], "R1 type", req_type, m_hdr[0]);
            check(req_code === m_hdr[1], "R1 code", req_code, m_hdr[1]);
            check(req_value === {m_hdr[3], m_hdr[2]}, "R1 value", req_value, {m_hdr[3], m_hdr[2]});
            check(req_index === {m_hdr[5], m_hdr[4]}, "R1 index", req_index, {m_hdr[5], m_hdr[4]});
            check(req_length === {m_hdr[7], m_hdr[6]}, "R1 length", req_length, {m_hdr[7], m_hdr[6]});
        end
        check(pl_valid === m_plv, "R3 pl_valid", pl_valid, m_plv);
        if (m_plv) check(pl_data === m_pld, "R3 pl_data", pl_data, m_pld);
        check(busy === (m_pos != 0 || m_inpay), "R13 busy", busy, (m_pos != 0 || m_inpay));
        check(err_status === m_err, "R8 err_status", err_status, m_err);
        check(tx_valid === (m_ph != 0), "R11 tx_valid", tx_valid, (m_ph != 0));
        if (m_ph != 0) check(tx_sym === m_txs, "R9 tx_sym", tx_sym, m_txs);
        if (req_done === 1'b1) begin dcount++; last_value = req_value; end
        if (pl_valid === 1'b1) pcount++;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic put(input bit st, input logic [7:0] d);
        rx_valid = 1; rx_sym = {st, d};
        tick();
        rx_valid = 0; rx_sym = '0; rx_overrun = 0; rx_frame_err = 0;
    endtask

    task automatic put_hdr(input logic [7:0] t, input logic [7:0] c,
                           input logic [15:0] v, input logic [15:0] x, input logic [15:0] l);
        put(1, t); put(0, c); put(0, v[7:0]); put(0, v[15:8]);
        put(0, x[7:0]); put(0, x[15:8]); put(0, l[7:0]); put(0, l[15:8]);
    endtask

    task automatic reply(input logic [7:0] ln);
        while (tx_busy) tick();
        rep_start = 1; rep_len = ln;
        tick();
        rep_start = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        int d0, p0;
        logic [8:0] held;
        bit ka_seen;
        repeat (3) tick();
        rst_n = 1;
        // R14: reset state
        check(req_done === 0 && busy === 0, "R14 idle after reset", busy, 0);
        check(err_status === 4'b0, "R14 errors clear", err_status, 0);
        check(tx_valid === 0, "R14 nothing sent", tx_valid, 0);

        // R4: stray bytes discarded
        d0 = dcount; p0 = pcount;
        put(0, 8'h11); put(0, 8'h22); tick(); tick();
        check(dcount == d0 && pcount == p0 && busy === 0, "R4 garbage dropped", dcount - d0, 0);

        // R2 + R1: device-to-host header-only request
        d0 = dcount; p0 = pcount;
        put_hdr(8'h83, 8'h10, 16'h1234, 16'h0002, 16'h0005);
        tick(); tick();
        check(dcount == d0 + 1 && pcount == p0, "R2 header-only done", dcount - d0, 1);
        check(last_value === 16'h1234, "R1 value low byte first", last_value, 16'h1234);

        // R9: reply without payload
        reply(8'd0);
        check(tx_sym === 9'h103, "R9 reply head no payload", tx_sym, 9'h103);
        tick();

        // R3: request with three payload bytes
        d0 = dcount; p0 = pcount;
        put_hdr(8'h06, 8'h20, 16'h0000, 16'h0001, 16'h0003);
        put(0, 8'hAA); put(0, 8'hBB); put(0, 8'hCC);
        tick(); tick();
        check(dcount == d0 + 1 && pcount == p0 + 3, "R3 payload count", pcount - p0, 3);
        reply(8'd2);
        check(tx_sym === 9'h186, "R9 reply head with payload", tx_sym, 9'h186);
        tick();
        check(tx_sym === 9'h002, "R9 length symbol", tx_sym, 9'h002);
        tick();

        // R5: restart during open header
        d0 = dcount;
        put(1, 8'h05); put(0, 8'h01); put(0, 8'h02);
        put_hdr(8'h05, 8'h01, 16'h0, 16'h0, 16'h0);
        tick(); tick();
        check(err_status[3] === 1'b1, "R5 timeout bit", err_status, 4'b1000);
        check(dcount == d0 + 1, "R5 restarted request completes", dcount - d0, 1);

        // R8: clear coinciding with a new frame error
        status_rd = 1; rx_frame_err = 1;
        put(0, 8'h33);
        status_rd = 0;
        check(err_status === 4'b0100, "R8 set wins over clear", err_status, 4'b0100);
        status_rd = 1; tick(); status_rd = 0;
        check(err_status === 4'b0000, "R8 read clears", err_status, 0);

        // R6 + R7: overflow while stalled, overrun flag
        cmd_stall = 1;
        for (int i = 0; i < CAP + 4; i++) begin
            if (i == 2) rx_overrun = 1;
            put(0, 8'(i));
        end
        cmd_stall = 0;
        repeat (CAP + 4) tick();
        check(err_status === 4'b0011, "R6 R7 overflow and overrun", err_status, 4'b0011);
        status_rd = 1; tick(); status_rd = 0;

        // R10: symbol held until accepted
        tx_ready = 0;
        reply(8'd1);
        held = tx_sym;
        for (int i = 0; i < 4; i++) begin
            tick();
            check(tx_valid === 1 && tx_sym === held, "R10 hold under backpressure", tx_sym, held);
        end
        tx_ready = 1;
        repeat (3) tick();

        // R11: keep-alive after idle
        ka_seen = 0;
        for (int i = 0; i < KA + 6; i++) begin
            tick();
            if (tx_valid && tx_sym === {1'b1, KAID}) ka_seen = 1;
        end
        check(ka_seen, "R11 keep-alive sent", ka_seen, 1);

        // R12: reply in the cycle a keep-alive falls due
        while (!(m_idle == KA + 1 && m_ph == 0)) tick();
        rep_start = 1; rep_len = 8'd0;
        tick();
        rep_start = 0;
        check(tx_sym === 9'h105, "R12 reply beats keep-alive", tx_sym, 9'h105);
        rep_start = 1; rep_len = 8'd7;
        tick();
        rep_start = 0;
        tick();
        check(tx_valid === 0, "R12 start while busy ignored", tx_valid, 0);
        repeat (3) tick();
        finish_run();
    end
endmodule